// File: doc/BRIEF.md
# Electrically Erasable Memory Pattern Self-Test Sequencer

This block runs a built-in self-test over an electrically erasable word memory through a single word-wide request port. A separate access block handles the byte-level timing of the memory. The test has three backgrounds, applied in a fixed order:

1. all zeros;
2. all ones;
3. each word's own address as its data.

For each background there is a write pass followed by a verify pass. In a write pass, every word is written and then read back at once, and the address advances only after the read-back matches. The verify pass that follows only reads and compares every word.

After the third verify pass, the sequencer lights a decimal-point indicator and then re-reads the address background forever. It never writes again, so leaving the test running cannot wear out the part. An external progress counter is driven by a one-cycle increment strobe and a one-cycle clear strobe. Any mismatch clears the counter and restarts the whole test from the zero background. The first failing address and the data read there are kept for inspection.

Top module: `nvm_pattern_bist`

## Requirements
- R1: After reset the sequencer is idle. In that state phase is 0 and busy, mem_req, prog_strobe, prog_clr, dp_on and err_sticky are all 0.
- R2: A start pulse while idle does three things: it emits one prog_clr pulse, it sets phase to 1, and it begins at word address 0 with a write. A start pulse while busy has no effect on the transfer stream or the clear count.
- R3: Phase codes are 1/2 for the zero-background write/verify passes, 3/4 for all ones (0xFFFF), 5/6 for the address background (address zero-extended), and 7 for the endless verify loop. Expected data follows the phase and the address.
- R4: In a write pass every word goes through a write transfer (mem_we=1, expected data), then a read transfer of the same address. Only a matching read advances the address.
- R5: A verify pass issues only read transfers, at ascending addresses from 0 to the last word. At the end of the pass the phase moves on.
- R6: prog_strobe pulses once for each word completed in a write pass and never during the first three verify passes. So when the address verify pass begins, the count equals three times the word count.
- R7: When the address verify pass completes, dp_on turns on and one strobe is emitted. The block then stays in phase 7, repeating the address verify pass with one strobe at the end of each pass, and issues no further write.
- R8: A read mismatch in any pass emits prog_clr, clears dp_on, and restarts at phase 1, address 0. The failing read produces no strobe, even when it is the last word of a pass.
- R9: The first mismatch sets err_sticky and latches fail_addr and fail_data. Later mismatches leave all three unchanged until reset.
- R10: mem_req, mem_we, mem_addr and mem_wdata stay stable while a request is pending (mem_req high without mem_done). A transfer completes on each cycle in which mem_req and mem_done are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the test when idle |
| mem_req | output | 1 | Transfer request to the access block |
| mem_we | output | 1 | 1 = write transfer, 0 = read transfer |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data (expected pattern) |
| mem_done | input | 1 | Transfer complete, one cycle per transfer |
| mem_rdata | input | DATA_W | Read data, valid with mem_done |
| busy | output | 1 | Test running |
| err_sticky | output | 1 | A mismatch has occurred since reset |
| phase | output | 3 | Current pass code |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_data | output | DATA_W | Data read at the first mismatch |
| prog_strobe | output | 1 | Progress counter increment pulse |
| prog_clr | output | 1 | Progress counter clear pulse |
| dp_on | output | 1 | Decimal-point indicator |

## Verification
The critical coincidence is a read mismatch on the last word of the address verify pass. That same completion would normally end the pass, light the decimal point and emit a strobe. The bench forces a single bit flip at exactly that read. It then judges that restart wins: one clear pulse, no strobe, dp_on left off, phase back to 1 at address 0, and the failing address latched. A second forced mismatch in the restarted run confirms that the first capture is kept.

// File: rtl/nvm_bist_pkg.sv
// Package: shared pass codes and helpers for the pattern self-test sequencer.
// Assumes: pass codes are visible at the top-level phase port unchanged.
package nvm_bist_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WR_ZERO = 3'd1,
        PH_VF_ZERO = 3'd2,
        PH_WR_ONES = 3'd3,
        PH_VF_ONES = 3'd4,
        PH_WR_ADDR = 3'd5,
        PH_VF_ADDR = 3'd6,
        PH_LOOP    = 3'd7
    } phase_e;

    // True for the three passes that write before reading back.
    function automatic logic is_write_phase(input phase_e p);
        return (p == PH_WR_ZERO) || (p == PH_WR_ONES) || (p == PH_WR_ADDR);
    endfunction

    // Pass that follows p once its last word has matched.
    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_WR_ZERO: return PH_VF_ZERO;
            PH_VF_ZERO: return PH_WR_ONES;
            PH_WR_ONES: return PH_VF_ONES;
            PH_VF_ONES: return PH_WR_ADDR;
            PH_WR_ADDR: return PH_VF_ADDR;
            default:    return PH_LOOP;
        endcase
    endfunction

endpackage

// File: rtl/nvm_bist_pattern.sv
// Module: expected-data generator.
// Produces the background word for the current pass and address.
// Assumes: purely combinational; address background is zero-extended or truncated to DATA_W.
module nvm_bist_pattern
    import nvm_bist_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  phase_e              phase,
    input  logic [ADDR_W-1:0]   addr,
    output logic [DATA_W-1:0]   expect_data
);

    logic [DATA_W-1:0] addr_pat;

    // Fit the word address into a data word.
    generate
        if (DATA_W > ADDR_W) begin : g_ext
            assign addr_pat = {{(DATA_W-ADDR_W){1'b0}}, addr};
        end else begin : g_trunc
            assign addr_pat = addr[DATA_W-1:0];
        end
    endgenerate

    // Select the background from the pass code.
    always_comb begin
        case (phase)
            PH_WR_ONES, PH_VF_ONES:           expect_data = '1;
            PH_WR_ADDR, PH_VF_ADDR, PH_LOOP:  expect_data = addr_pat;
            default:                          expect_data = '0;
        endcase
    end

endmodule

// File: rtl/nvm_bist_capture.sv
// Module: first-failure capture.
// Latches the address and read data of the first mismatch and holds a sticky flag.
// Assumes: hit is a one-cycle event; only reset clears the record.
module nvm_bist_capture #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   rdata,
    output logic                err_sticky,
    output logic [ADDR_W-1:0]   fail_addr,
    output logic [DATA_W-1:0]   fail_data
);

    // Record only the first mismatch since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_sticky <= 1'b0;
            fail_addr  <= '0;
            fail_data  <= '0;
        end else if (hit && !err_sticky) begin
            err_sticky <= 1'b1;
            fail_addr  <= addr;
            fail_data  <= rdata;
        end
    end

endmodule

// File: rtl/nvm_bist_seq.sv
// Module: pass sequencer.
// Walks the addresses, alternates write/read-back in write passes, moves through
// the passes and emits the progress strobes and the indicator.
// Assumes: mem_done is only meaningful while a request is pending (phase not idle).
module nvm_bist_seq
    import nvm_bist_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mem_done,
    input  logic                match,
    output phase_e              phase,
    output logic                op_write,
    output logic [ADDR_W-1:0]   addr,
    output logic                mismatch,
    output logic                prog_strobe,
    output logic                prog_clr,
    output logic                dp_on
);

    logic   last_word;
    phase_e after_last;
    phase_e adv_phase;

    // Decode end of pass and the pass reached after this word.
    always_comb begin
        last_word  = &addr;
        after_last = next_phase(phase);
        adv_phase  = last_word ? after_last : phase;
        mismatch   = (phase != PH_IDLE) && mem_done && !op_write && !match;
    end

    // Main sequencing register set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            op_write    <= 1'b1;
            addr        <= '0;
            prog_strobe <= 1'b0;
            prog_clr    <= 1'b0;
            dp_on       <= 1'b0;
        end else begin
            prog_strobe <= 1'b0;
            prog_clr    <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    phase    <= PH_WR_ZERO;
                    op_write <= 1'b1;
                    addr     <= '0;
                    prog_clr <= 1'b1;
                end
            end else if (mem_done) begin
                if (op_write) begin
                    op_write <= 1'b0;
                end else if (!match) begin
                    phase    <= PH_WR_ZERO;
                    op_write <= 1'b1;
                    addr     <= '0;
                    prog_clr <= 1'b1;
                    dp_on    <= 1'b0;
                end else begin
                    addr        <= addr + 1'b1;
                    phase       <= adv_phase;
                    op_write    <= is_write_phase(adv_phase);
                    prog_strobe <= is_write_phase(phase) ||
                                   (last_word && ((phase == PH_VF_ADDR) || (phase == PH_LOOP)));
                    if (last_word && (phase == PH_VF_ADDR)) begin
                        dp_on <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/nvm_pattern_bist.sv
// Module: top of the pattern self-test sequencer.
// Joins the sequencer, the pattern generator and the failure capture, and
// presents one word-transfer request to the access block.
// Assumes: access block completes each transfer with a one-cycle mem_done while
// mem_req is high; read data is valid in the same cycle as mem_done.
module nvm_pattern_bist
    import nvm_bist_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_done,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                busy,
    output logic                err_sticky,
    output logic [2:0]          phase,
    output logic [ADDR_W-1:0]   fail_addr,
    output logic [DATA_W-1:0]   fail_data,
    output logic                prog_strobe,
    output logic                prog_clr,
    output logic                dp_on
);

    phase_e              cur_phase;
    logic                op_write;
    logic [ADDR_W-1:0]   word_addr;
    logic [DATA_W-1:0]   expect_data;
    logic                match;
    logic                mismatch;

    nvm_bist_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mem_done    (mem_done),
        .match       (match),
        .phase       (cur_phase),
        .op_write    (op_write),
        .addr        (word_addr),
        .mismatch    (mismatch),
        .prog_strobe (prog_strobe),
        .prog_clr    (prog_clr),
        .dp_on       (dp_on)
    );

    nvm_bist_pattern #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pat (
        .phase       (cur_phase),
        .addr        (word_addr),
        .expect_data (expect_data)
    );

    nvm_bist_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (mismatch),
        .addr       (word_addr),
        .rdata      (mem_rdata),
        .err_sticky (err_sticky),
        .fail_addr  (fail_addr),
        .fail_data  (fail_data)
    );

    // Drive the request port and compare the returned word.
    always_comb begin
        busy      = (cur_phase != PH_IDLE);
        mem_req   = busy;
        mem_we    = busy && op_write;
        mem_addr  = word_addr;
        mem_wdata = expect_data;
        match     = (mem_rdata == expect_data);
        phase     = cur_phase;
    end

endmodule

// File: rtl/nvm_pattern_bist_chk.sv
// Module: protocol and sequencing checker bound to the top.
// Assumes: sampled on the top clock; all properties disabled during reset.
module nvm_pattern_bist_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mem_req,
    input  logic                mem_we,
    input  logic [ADDR_W-1:0]   mem_addr,
    input  logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_done,
    input  logic                err_sticky,
    input  logic [2:0]          phase,
    input  logic [ADDR_W-1:0]   fail_addr,
    input  logic [DATA_W-1:0]   fail_data,
    input  logic                prog_strobe,
    input  logic                prog_clr,
    input  logic                dp_on
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0) |-> (!mem_req && !prog_strobe && !dp_on));

    a_r10_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    a_r4_readback_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_done) |=> (mem_req && !mem_we && $stable(mem_addr)));

    a_r7_no_write_in_loop: assert property (@(posedge clk) disable iff (!rst_n)
        dp_on |-> !mem_we);

    a_r6_strobe_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        prog_strobe |-> $past(mem_req && mem_done));

    a_r8_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        prog_clr |-> (phase == 3'd1 && mem_addr == '0 && mem_we && !dp_on && !prog_strobe));

    a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> (err_sticky && $stable(fail_addr) && $stable(fail_data)));

endmodule

bind nvm_pattern_bist nvm_pattern_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_done    (mem_done),
    .err_sticky  (err_sticky),
    .phase       (phase),
    .fail_addr   (fail_addr),
    .fail_data   (fail_data),
    .prog_strobe (prog_strobe),
    .prog_clr    (prog_clr),
    .dp_on       (dp_on)
);

// File: tb/nvm_pattern_bist_tb.sv
// Bench: scoreboard of expected transfers, popped by a memory responder.
module nvm_pattern_bist_tb;

    localparam int AW = 5;
    localparam int DW = 16;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mem_req, mem_we, mem_done;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, fail_data;
    logic          busy, err_sticky, prog_strobe, prog_clr, dp_on;
    logic [2:0]    phase;

    always #2 clk = ~clk;

    nvm_pattern_bist #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_done(mem_done), .mem_rdata(mem_rdata),
        .busy(busy), .err_sticky(err_sticky), .phase(phase),
        .fail_addr(fail_addr), .fail_data(fail_data),
        .prog_strobe(prog_strobe), .prog_clr(prog_clr), .dp_on(dp_on)
    );

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [DW-1:0] flip;
    } xfer_t;

    xfer_t         q[$];
    logic [DW-1:0] mem [0:N-1];
    int            n_chk = 0;
    int            n_bad = 0;
    int            n_strobe = 0;
    int            n_clr = 0;
    int            snap [0:7];
    logic [2:0]    prev_phase = 3'd0;
    bit            dp_early = 1'b0;
    int            wait_cnt = 0;
    int            lat = 0;
    int            cycles = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] bg(input int ph, input int a);
        if (ph == 3 || ph == 4) return '1;
        if (ph >= 5) return DW'(a);
        return '0;
    endfunction

    task automatic push(input logic we, input int a, input logic [DW-1:0] d, input logic [DW-1:0] f);
        xfer_t x;
        x.we = we; x.addr = AW'(a); x.data = d; x.flip = f;
        q.push_back(x);
    endtask

    // Driver: expected transfers of one whole pass.
    task automatic push_pass(input int ph);
        for (int a = 0; a < N; a++) begin
            if (ph == 1 || ph == 3 || ph == 5) push(1'b1, a, bg(ph, a), '0);
            push(1'b0, a, bg(ph, a), '0);
        end
    endtask

    // Monitor/responder: completes transfers, compares them with the queue head.
    always @(negedge clk) begin
        mem_done = 1'b0;
        if (!rst_n) begin
            wait_cnt = 0;
        end else if (mem_req && q.size() > 0) begin
            if (wait_cnt < lat) begin
                wait_cnt++;
            end else begin
                xfer_t x;
                wait_cnt = 0;
                lat = (lat + 1) % 3;
                x = q.pop_front();
                chk(mem_we == x.we, "R4/R5", "transfer kind", 32'(mem_we), 32'(x.we));
                chk(mem_addr == x.addr, "R5", "transfer address", 32'(mem_addr), 32'(x.addr));
                if (x.we) begin
                    chk(mem_wdata == x.data, "R3", "write data", 32'(mem_wdata), 32'(x.data));
                    mem[mem_addr] = mem_wdata;
                end
                mem_rdata = mem[mem_addr] ^ x.flip;
                mem_done = 1'b1;
            end
        end
    end

    // Strobe counters and per-phase snapshots (R6, R7).
    always @(negedge clk) begin
        if (rst_n) begin
            if (prog_strobe) n_strobe++;
            if (prog_clr) n_clr++;
            if (dp_on && phase != 3'd7) dp_early = 1'b1;
            if (phase != prev_phase && snap[phase] < 0) snap[phase] = n_strobe;
            prev_phase = phase;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        q.delete();
        for (int a = 0; a < N; a++) mem[a] = 16'hA5A5;
        repeat (3) @(negedge clk);
        n_strobe = 0; n_clr = 0; dp_early = 1'b0; prev_phase = 3'd0;
        for (int p = 0; p < 8; p++) snap[p] = -1;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        mem_done = 1'b0;
        mem_rdata = '0;
        for (int p = 0; p < 8; p++) snap[p] = -1;
        do_reset();

        // R1: reset state.
        chk(phase == 3'd0, "R1", "phase", 32'(phase), 0);
        chk(!busy && !mem_req, "R1", "busy/req", 32'({busy, mem_req}), 0);
        chk(!prog_strobe && !prog_clr && !dp_on && !err_sticky, "R1", "flags",
            32'({prog_strobe, prog_clr, dp_on, err_sticky}), 0);

        // Clean run: all passes plus two loop passes.
        for (int p = 1; p <= 6; p++) push_pass(p);
        push_pass(7); push_pass(7);
        pulse_start();
        chk(phase == 3'd1 && mem_addr == '0 && mem_we, "R2", "start state",
            32'({phase, mem_we}), 32'({3'd1, 1'b1}));
        repeat (5 * N) @(negedge clk);
        pulse_start();  // R2: ignored while busy
        wait (q.size() == 0);
        repeat (6) @(negedge clk);
        chk(n_clr == 1, "R2", "clear pulses", 32'(n_clr), 1);
        chk(snap[2] == N, "R6", "strobes at zero verify", 32'(snap[2]), 32'(N));
        chk(snap[3] == N, "R6", "strobes at ones write", 32'(snap[3]), 32'(N));
        chk(snap[5] == 2 * N, "R6", "strobes at address write", 32'(snap[5]), 32'(2 * N));
        chk(snap[6] == 3 * N, "R6", "strobes at address verify", 32'(snap[6]), 32'(3 * N));
        chk(snap[7] == 3 * N + 1, "R7", "strobes entering loop", 32'(snap[7]), 32'(3 * N + 1));
        chk(n_strobe == 3 * N + 3, "R7", "strobes after two loops", 32'(n_strobe), 32'(3 * N + 3));
        chk(phase == 3'd7 && dp_on, "R7", "loop phase and indicator", 32'({phase, dp_on}), 32'({3'd7, 1'b1}));
        chk(!dp_early, "R7", "indicator early", 32'(dp_early), 0);
        chk(!err_sticky, "R9", "no false error", 32'(err_sticky), 0);

        // Fault run: mismatch on last word of address verify, then another one.
        do_reset();
        for (int p = 1; p <= 5; p++) push_pass(p);
        for (int a = 0; a < N; a++) push(1'b0, a, bg(6, a), (a == N - 1) ? 16'h8000 : 16'h0000);
        push(1'b1, 0, 0, 0); push(1'b0, 0, 0, 0);
        push(1'b1, 1, 0, 0); push(1'b0, 1, 0, 0);
        push(1'b1, 2, 0, 0); push(1'b0, 2, 0, 16'h0001);
        push(1'b1, 0, 0, 0); push(1'b0, 0, 0, 0);
        push(1'b1, 1, 0, 0); push(1'b0, 1, 0, 0);
        pulse_start();
        wait (q.size() == 0);
        repeat (6) @(negedge clk);
        chk(err_sticky, "R9", "sticky error", 32'(err_sticky), 1);
        chk(fail_addr == AW'(N - 1), "R9", "first fail address", 32'(fail_addr), 32'(N - 1));
        chk(fail_data == (DW'(N - 1) ^ 16'h8000), "R9", "first fail data",
            32'(fail_data), 32'(DW'(N - 1) ^ 16'h8000));
        chk(!dp_on && snap[7] < 0, "R8", "no loop after last-word fail", 32'(dp_on), 0);
        chk(n_strobe == 3 * N + 4, "R8", "no strobe on failing read", 32'(n_strobe), 32'(3 * N + 4));
        chk(n_clr == 3, "R8", "clear pulses", 32'(n_clr), 3);
        chk(phase == 3'd1 && mem_addr == AW'(2) && mem_we, "R8", "restarted position",
            32'({phase, mem_addr}), 32'({3'd1, AW'(2)}));
        chk(mem_req && mem_wdata == '0, "R10", "pending request held", 32'({mem_req, mem_wdata}), 32'(1 << DW));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule